// File: doc/BRIEF.md
# HEC Cell Delineator with Clear-on-Read Interrupt Status

This block finds ATM cell boundaries in a received stream of octets. It looks for a five-byte window in which the last byte is the header check of the four bytes before it. When such a window turns up, the block locks onto a 53-byte grid and confirms the lock over the cells that follow. Once the grid is trusted, the block marks each cell start. It also watches each header for operation-and-maintenance traffic. While the grid is not trusted, it holds a loss-of-delineation output high.

Three kinds of event are reported through a byte-wide status register that a microprocessor reads: a header check mismatch, a change in the loss-of-delineation level, and the end of a maintenance cell. Each status bit holds its event until the register is read, and the read clears it. A second register shows the live loss-of-delineation level and the state code. With these, software can tell whether a level-change event meant gaining the grid or losing it. An interrupt request output combines the status bits with a per-bit enable input.

Top module: `cell_delin_irq`

## Requirements
- R1: After reset, `lcd` is 1 and `irq` is 0. The status register reads 0x00. The configuration register reads 0x80.
- R2: The header check is the CRC-8 with generator x^8+x^2+x+1, taken MSB first over the four header bytes and then XORed with 0x55. In the search state the block tests every byte position. The first byte that completes a matching five-byte window moves it to the confirm state (state code 1). No status bit is set by this step.
- R3: In the confirm state the check runs at byte 4 of each 53-byte cell. Six correct checks in a row move the block to the locked state (code 2) and drive `lcd` low. A single failing check sends it back to the search state (code 0).
- R4: In the locked state, seven failing checks in a row move the block to the search state and raise `lcd`. A correct check resets that run, so six failures, then one pass, then six more failures keep the lock.
- R5: Status bit 1 is set when the block enters the locked state and when it leaves it. Nothing else sets it.
- R6: Status bit 0 is set by a failing check in the confirm or locked state.
- R7: A cell whose check passes in the locked state sets status bit 2 when its last byte (index 52) arrives, if it is a maintenance cell. A maintenance cell has a VCI (header bits 19:4) of 3 or 4, or a PTI (bits 3:1) of 4 or 5. The header is taken as GFC 31:28, VPI 27:20, VCI 19:4, PTI 3:1, CLP 0.
- R8: Address 0 is the status register, and its bits 7:3 read 0. A read returns the value in `rd_data` on the cycle after `rd_en`, and clears every status bit. An event that arrives in the same cycle as the read is not part of the returned value. It stays set for the next read.
- R9: `irq` is high exactly when some status bit and its bit of `irq_en` are both 1.
- R10: Address 1 reads as {lcd, 5'b0, state code}. Addresses 2 and 3 read 0x00.
- R11: In the locked state, `cell_start` pulses for one cycle, in the cycle after byte 0 of each cell is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| rx_byte | input | 8 | Received octet |
| rx_valid | input | 1 | High when `rx_byte` holds a new octet |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register address |
| irq_en | input | 3 | Interrupt enable, one bit per status bit |
| rd_data | output | 8 | Read data, loaded on the cycle after `rd_en` |
| cell_start | output | 1 | One-cycle marker of a cell start while locked |
| lcd | output | 1 | Loss of cell delineation, high unless locked |
| irq | output | 1 | Interrupt request |

## Verification
A status read and a new event can fall in the same clock cycle. The bench provokes this by raising the read strobe together with a corrupted check byte while the block is locked. The returned value must not contain the header-error bit. The next read must show that bit set. The stimulus table pairs header contents and corruption with the expected status byte after each cell, and this covers both maintenance flow types and their near misses.

// File: rtl/cd_pkg.sv
package cd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } dl_state_e;

  localparam int unsigned HDR_BYTES  = 4;
  localparam int unsigned HDR_W      = 8 * HDR_BYTES;
  localparam int unsigned WIN_W      = HDR_W + 8;
  localparam logic [7:0]  HEC_POLY   = 8'h07;
  localparam logic [7:0]  HEC_COSET  = 8'h55;

  localparam int unsigned STAT_HEC   = 0;
  localparam int unsigned STAT_LCD   = 1;
  localparam int unsigned STAT_OAM   = 2;
  localparam int unsigned STAT_W     = 3;

  localparam logic [1:0]  ADDR_STAT  = 2'd0;
  localparam logic [1:0]  ADDR_CFG   = 2'd1;

  function automatic logic [7:0] hec_calc(input logic [HDR_W-1:0] hdr);
    logic [7:0] crc;
    crc = 8'h00;
    for (int i = HDR_W - 1; i >= 0; i--) begin
      if (crc[7] ^ hdr[i]) crc = {crc[6:0], 1'b0} ^ HEC_POLY;
      else                 crc = {crc[6:0], 1'b0};
    end
    return crc ^ HEC_COSET;
  endfunction

endpackage

// File: rtl/cd_hec_window.sv
module cd_hec_window
  import cd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [7:0]  in_byte,
  output logic        hec_match,
  output logic        win_full,
  output logic [15:0] hdr_vci,
  output logic [2:0]  hdr_pti
);

  localparam int unsigned FILL_W = $clog2(HDR_BYTES + 1);

  logic [WIN_W-1:0]  win_q, win_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [HDR_W-1:0]  hdr_now;

  // window as it stands once the incoming byte is included
  always_comb begin
    win_d  = {win_q[WIN_W-9:0], in_byte};
    fill_d = fill_q;
    if (fill_q != FILL_W'(HDR_BYTES)) fill_d = fill_q + 1'b1;
  end

  assign hdr_now   = win_d[WIN_W-1:8];
  assign hec_match = (hec_calc(hdr_now) == win_d[7:0]);
  assign win_full  = (fill_q == FILL_W'(HDR_BYTES));
  assign hdr_vci   = hdr_now[19:4];
  assign hdr_pti   = hdr_now[3:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (in_vld) begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

  // R2
  fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_full |=> win_full);

endmodule

// File: rtl/cd_framer.sv
module cd_framer
  import cd_pkg::*;
#(
  parameter int unsigned CELL_BYTES   = 53,
  parameter int unsigned PRESYNC_GOOD = 6,
  parameter int unsigned SYNC_BAD     = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic        hec_match,
  input  logic        win_full,
  input  logic [15:0] hdr_vci,
  input  logic [2:0]  hdr_pti,
  output dl_state_e   state_o,
  output logic        lcd_o,
  output logic        cell_start_o,
  output logic        ev_hec_o,
  output logic        ev_lcd_o,
  output logic        ev_oam_o
);

  localparam int unsigned POS_W   = $clog2(CELL_BYTES);
  localparam int unsigned CNT_MAX = (PRESYNC_GOOD > SYNC_BAD) ? PRESYNC_GOOD : SYNC_BAD;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [POS_W-1:0] POS_HEC  = POS_W'(HDR_BYTES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CELL_BYTES - 1);
  localparam logic [POS_W-1:0] POS_PAST = POS_W'(HDR_BYTES + 1);

  dl_state_e        state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d, pos_adv;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             oam_pend_q, oam_pend_d;
  logic             start_q, start_d;
  logic             is_oam, at_hec;

  assign pos_adv = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  assign at_hec  = (pos_q == POS_HEC);
  assign is_oam  = (hdr_vci == 16'd3) || (hdr_vci == 16'd4) ||
                   (hdr_pti == 3'd4)  || (hdr_pti == 3'd5);

  always_comb begin
    state_d    = state_q;
    pos_d      = pos_q;
    cnt_d      = cnt_q;
    oam_pend_d = oam_pend_q;
    start_d    = 1'b0;
    ev_hec_o   = 1'b0;
    ev_lcd_o   = 1'b0;
    ev_oam_o   = 1'b0;
    if (in_vld) begin
      unique case (state_q)
        ST_HUNT: begin
          oam_pend_d = 1'b0;
          if (win_full && hec_match) begin
            state_d = ST_PRESYNC;
            pos_d   = POS_PAST;
            cnt_d   = '0;
          end
        end
        ST_PRESYNC: begin
          pos_d = pos_adv;
          if (at_hec) begin
            if (hec_match) begin
              if (cnt_q == CNT_W'(PRESYNC_GOOD - 1)) begin
                state_d  = ST_SYNC;
                cnt_d    = '0;
                ev_lcd_o = 1'b1;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end else begin
              state_d  = ST_HUNT;
              cnt_d    = '0;
              ev_hec_o = 1'b1;
            end
          end
        end
        ST_SYNC: begin
          pos_d   = pos_adv;
          start_d = (pos_q == '0);
          if (at_hec) begin
            if (hec_match) begin
              cnt_d      = '0;
              oam_pend_d = is_oam;
            end else begin
              ev_hec_o   = 1'b1;
              oam_pend_d = 1'b0;
              if (cnt_q == CNT_W'(SYNC_BAD - 1)) begin
                state_d  = ST_HUNT;
                cnt_d    = '0;
                ev_lcd_o = 1'b1;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end
          if ((pos_q == POS_LAST) && oam_pend_q) begin
            ev_oam_o   = 1'b1;
            oam_pend_d = 1'b0;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      pos_q      <= '0;
      cnt_q      <= '0;
      oam_pend_q <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      pos_q      <= pos_d;
      cnt_q      <= cnt_d;
      oam_pend_q <= oam_pend_d;
      start_q    <= start_d;
    end
  end

  assign state_o      = state_q;
  assign lcd_o        = (state_q != ST_SYNC);
  assign cell_start_o = start_q;

  // R3
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT) |=> (state_q != ST_SYNC));

  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC && in_vld && at_hec && hec_match) |=> (state_q == ST_SYNC));

  // R11
  start_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ($past(state_q) == ST_SYNC));

endmodule

// File: rtl/cd_irq_regs.sv
module cd_irq_regs
  import cd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_hec,
  input  logic              ev_lcd,
  input  logic              ev_oam,
  input  dl_state_e         state_i,
  input  logic              lcd_i,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  input  logic [STAT_W-1:0] irq_en,
  output logic [7:0]        rd_data,
  output logic              irq
);

  logic [STAT_W-1:0] stat_q, stat_d, ev_vec;
  logic [7:0]        rd_q, rd_d, rd_sel;
  logic              rd_clr;

  assign rd_clr = rd_en && (rd_addr == ADDR_STAT);

  always_comb begin
    ev_vec           = '0;
    ev_vec[STAT_HEC] = ev_hec;
    ev_vec[STAT_LCD] = ev_lcd;
    ev_vec[STAT_OAM] = ev_oam;
    stat_d = ev_vec | (stat_q & ~{STAT_W{rd_clr}});
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_STAT: rd_sel = {{(8-STAT_W){1'b0}}, stat_q};
      ADDR_CFG:  rd_sel = {lcd_i, 5'b0, state_i};
      default:   rd_sel = 8'h00;
    endcase
    rd_d = rd_en ? rd_sel : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rd_q   <= '0;
    end else begin
      stat_q <= stat_d;
      rd_q   <= rd_d;
    end
  end

  assign rd_data = rd_q;
  assign irq     = |(stat_q & irq_en);

  // R8
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_clr) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_clr) && !$past(ev_hec)) |-> !stat_q[STAT_HEC]);

  // R5
  lcd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_lcd) |-> stat_q[STAT_LCD]);

endmodule

// File: rtl/cell_delin_irq.sv
module cell_delin_irq
  import cd_pkg::*;
#(
  parameter int unsigned CELL_BYTES   = 53,
  parameter int unsigned PRESYNC_GOOD = 6,
  parameter int unsigned SYNC_BAD     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  input  logic [2:0] irq_en,
  output logic [7:0] rd_data,
  output logic       cell_start,
  output logic       lcd,
  output logic       irq
);

  logic [1:0]  rst_pipe_q;
  logic        rst_n_i;
  logic        hec_match, win_full;
  logic [15:0] hdr_vci;
  logic [2:0]  hdr_pti;
  dl_state_e   state;
  logic        ev_hec, ev_lcd, ev_oam;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  cd_hec_window u_win (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .in_vld    (rx_valid),
    .in_byte   (rx_byte),
    .hec_match (hec_match),
    .win_full  (win_full),
    .hdr_vci   (hdr_vci),
    .hdr_pti   (hdr_pti)
  );

  cd_framer #(
    .CELL_BYTES   (CELL_BYTES),
    .PRESYNC_GOOD (PRESYNC_GOOD),
    .SYNC_BAD     (SYNC_BAD)
  ) u_frm (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .in_vld       (rx_valid),
    .hec_match    (hec_match),
    .win_full     (win_full),
    .hdr_vci      (hdr_vci),
    .hdr_pti      (hdr_pti),
    .state_o      (state),
    .lcd_o        (lcd),
    .cell_start_o (cell_start),
    .ev_hec_o     (ev_hec),
    .ev_lcd_o     (ev_lcd),
    .ev_oam_o     (ev_oam)
  );

  cd_irq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ev_hec  (ev_hec),
    .ev_lcd  (ev_lcd),
    .ev_oam  (ev_oam),
    .state_i (state),
    .lcd_i   (lcd),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .irq_en  (irq_en),
    .rd_data (rd_data),
    .irq     (irq)
  );

endmodule

// File: tb/cell_delin_irq_test.sv
module cell_delin_irq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rd_en;
  logic [1:0] rd_addr;
  logic [2:0] irq_en;
  logic [7:0] rd_data;
  logic       cell_start;
  logic       lcd;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int cs_cnt = 0;
  logic [7:0] rv;

  // {vci, pti, corrupt, expected status}
  localparam logic [22:0] VEC [0:NVEC-1] = '{
    {16'd3,  3'd0, 1'b0, 3'b100},
    {16'd4,  3'd0, 1'b0, 3'b100},
    {16'd5,  3'd0, 1'b0, 3'b000},
    {16'd32, 3'd4, 1'b0, 3'b100},
    {16'd32, 3'd5, 1'b0, 3'b100},
    {16'd32, 3'd6, 1'b0, 3'b000},
    {16'd32, 3'd3, 1'b0, 3'b000},
    {16'd2,  3'd0, 1'b0, 3'b000},
    {16'd3,  3'd0, 1'b1, 3'b001}
  };

  cell_delin_irq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .irq_en     (irq_en),
    .rd_data    (rd_data),
    .cell_start (cell_start),
    .lcd        (lcd),
    .irq        (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (cell_start) cs_cnt++;

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int b = 31; b >= 0; b--) begin
      logic fb = c[7] ^ h[b];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c ^ 8'h55;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic with_rd);
    rx_byte  = b;
    rx_valid = 1'b1;
    rd_en    = with_rd;
    rd_addr  = 2'd0;
    tick();
    rx_valid = 1'b0;
    rd_en    = 1'b0;
  endtask

  task automatic send_cell(input logic [15:0] vci, input logic [2:0] pti,
                           input logic bad, input int rd_at);
    logic [31:0] h;
    logic [7:0]  hc;
    h  = {4'h0, 8'h21, vci, pti, 1'b0};
    hc = ref_hec(h) ^ (bad ? 8'h01 : 8'h00);
    for (int k = 0; k < 53; k++) begin
      logic [7:0] b;
      if (k < 4)       b = h[31-8*k -: 8];
      else if (k == 4) b = hc;
      else             b = 8'h6A;
      send_byte(b, k == rd_at);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    rd_en   = 1'b1;
    rd_addr = a;
    tick();
    rd_en   = 1'b0;
    d       = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_byte = 8'h00; rx_valid = 1'b0;
    rd_en = 1'b0; rd_addr = 2'd0; irq_en = 3'b111;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    check("R1 lcd", {7'b0, lcd}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    read_reg(2'd0, rv); check("R1 status", rv, 8'h00);
    read_reg(2'd1, rv); check("R10 cfg after reset", rv, 8'h80);

    // R2 search from an arbitrary offset
    repeat (3) send_byte(8'h11, 1'b0);
    send_cell(16'd40, 3'd0, 1'b0, -1);
    read_reg(2'd1, rv); check("R2 confirm state", rv, 8'h81);
    read_reg(2'd0, rv); check("R2 no flag on search exit", rv, 8'h00);

    // R3 failure in confirm returns to search, R6 flags it
    send_cell(16'd40, 3'd0, 1'b1, -1);
    read_reg(2'd1, rv); check("R3 back to search", rv, 8'h80);
    read_reg(2'd0, rv); check("R6 hec flag in confirm", rv, 8'h01);

    // R3 six good checks needed
    send_cell(16'd40, 3'd0, 1'b0, -1);
    repeat (5) send_cell(16'd40, 3'd0, 1'b0, -1);
    check("R3 still unlocked after five", {7'b0, lcd}, 8'h01);
    read_reg(2'd1, rv); check("R3 still confirm", rv, 8'h81);
    send_cell(16'd40, 3'd0, 1'b0, -1);
    check("R3 lcd low after sixth", {7'b0, lcd}, 8'h00);
    read_reg(2'd1, rv); check("R10 cfg locked", rv, 8'h02);

    // R9 masking, then R5 and R8
    irq_en = 3'b010; #1;
    check("R9 irq enabled bit", {7'b0, irq}, 8'h01);
    irq_en = 3'b101; #1;
    check("R9 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 3'b111;
    read_reg(2'd0, rv); check("R5 lock flag", rv, 8'h02);
    read_reg(2'd0, rv); check("R8 cleared by read", rv, 8'h00);
    check("R9 irq low when clear", {7'b0, irq}, 8'h00);

    // R7 / R6 / R11 stimulus table
    cs_cnt = 0;
    for (int i = 0; i < NVEC; i++) begin
      send_cell(VEC[i][22:7], VEC[i][6:4], VEC[i][3], -1);
      read_reg(2'd0, rv);
      check($sformatf("R7 table entry %0d", i), rv, {5'b0, VEC[i][2:0]});
    end
    check("R11 cell_start count", 8'(cs_cnt), 8'(NVEC));

    // R8 event in the same cycle as a read
    send_cell(16'd40, 3'd0, 1'b1, 4);
    check("R8 same-cycle read value", rd_data, 8'h00);
    read_reg(2'd0, rv); check("R8 same-cycle event kept", rv, 8'h01);

    // R4 loss of lock
    send_cell(16'd40, 3'd0, 1'b0, -1);
    repeat (6) send_cell(16'd40, 3'd0, 1'b1, -1);
    check("R4 six failures keep lock", {7'b0, lcd}, 8'h00);
    send_cell(16'd40, 3'd0, 1'b0, -1);
    repeat (6) send_cell(16'd40, 3'd0, 1'b1, -1);
    check("R4 run reset by a pass", {7'b0, lcd}, 8'h00);
    send_cell(16'd40, 3'd0, 1'b1, -1);
    check("R4 seventh failure loses lock", {7'b0, lcd}, 8'h01);
    read_reg(2'd1, rv); check("R10 cfg after loss", rv, 8'h80);
    read_reg(2'd0, rv); check("R5 loss flag with hec", rv, 8'h03);
    read_reg(2'd3, rv); check("R10 unused address", rv, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule